// File: doc/BRIEF.md
# OFDM Downlink Frame Timing Controller

This block is a free-running timing sequencer for a downlink OFDM transmitter. Three nested counts advance on every enabled clock: the sample within the current symbol, the symbol within the current slot, and the slot within the frame. Every sample of every symbol is one clock. From these counts the block decodes per-sample control strobes. It flags the guard-interval (cyclic prefix) region and the useful 512-sample region, marks the two symbols of each half-frame that carry primary and secondary synchronisation, pulses once per frame at its first sample, and sends a start pulse to a downstream IFFT a fixed lead ahead of that IFFT's first input sample.

The symbol length changes within a slot. The symbol that opens a slot has a 40-sample guard, and the remaining six have 36-sample guards, so the slot holds 552 + 6 x 548 = 3840 clocks. The frame holds 20 slots, which is 76800 clocks. A two-state machine tracks whether the current sample lies in the guard or the useful part. Its states are `PH_GUARD` and `PH_BODY`. The transition `PH_GUARD -> PH_BODY` is taken on the last guard sample of a symbol. The transition `PH_BODY -> PH_GUARD` is taken on the last sample of a symbol. Reset enters `PH_GUARD`, and the state holds while enable is low. The strobes are combinational decodes of the registered counts and state, so they describe the sample whose index is currently on the outputs.

Top module: `ofdm_frame_sequencer`

## Requirements
- R1: A synchronous active-high reset sets the slot, symbol and sample indices to 0 and puts the machine in `PH_GUARD`.
- R2: While enabled, the sample index counts 0, 1, 2 and so on, one step per clock. It wraps to 0 after 551 in symbol 0 of a slot, and after 547 in symbols 1 to 6.
- R3: `guard_flag` is high for exactly samples 0..39 of symbol 0 and 0..35 of the other symbols. `body_flag` is high for exactly the 512 samples that follow. The two flags are never high together.
- R4: The symbol index advances only after the last sample of a symbol and wraps 6 -> 0. When it wraps, the slot index advances, and the slot index wraps 19 -> 0.
- R5: `psync_flag` is high for every sample of symbol 6 in slots 0 and 10, and low at all other times.
- R6: `ssync_flag` is high for every sample of symbol 5 in slots 0 and 10, and low at all other times.
- R7: `ifft_start` is a one-cycle pulse at sample 37 of symbol 0 and at sample 33 of symbols 1 to 6. With enable held high, this is exactly 3 clocks before `body_flag` rises, in every symbol.
- R8: `frame_start` is high for one cycle, on sample 0 of symbol 0 of slot 0.
- R9: While `en` is low, all three indices hold their values, and `guard_flag`, `body_flag`, `psync_flag`, `ssync_flag`, `ifft_start` and `frame_start` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance enable; when low the sequencer freezes and its strobes are forced low |
| guard_flag | output | 1 | Current sample is in the cyclic-prefix region |
| body_flag | output | 1 | Current sample is in the useful region |
| psync_flag | output | 1 | Current symbol carries primary sync |
| ssync_flag | output | 1 | Current symbol carries secondary sync |
| ifft_start | output | 1 | IFFT start pulse, 3 clocks before useful data |
| frame_start | output | 1 | First sample of the frame |
| slot_idx | output | 5 | Slot index 0..19 |
| sym_idx | output | 3 | Symbol index in slot 0..6 |
| sample_idx | output | 10 | Sample index in symbol |

## Verification
The guard length is selected from the symbol index, so a wrong symbol count also moves every boundary that follows it. A corrupted count or phase shows up within one symbol, which is at most 552 clocks. It appears as a misplaced `body_flag` edge, an IFFT pulse at the wrong offset, or a sync flag in the wrong slot. An error in the slot counter may stay hidden until the next sync slot or frame wrap, up to 38400 clocks later. For that reason the bench compares every cycle of one complete frame against an independent model and also checks anchor points at the frame boundary.

// File: rtl/ofdm_seq_pkg.sv
package ofdm_seq_pkg;
    typedef enum logic [0:0] {
        PH_GUARD = 1'b0,
        PH_BODY  = 1'b1
    } phase_t;

    typedef struct packed {
        logic guard;
        logic body;
        logic psync;
        logic ssync;
        logic ifft_go;
        logic frame_go;
    } strobe_t;
endpackage

// File: rtl/ofdm_wrap_counter.sv
module ofdm_wrap_counter #(
    parameter int LIMIT = 7,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] value,
    output logic         at_last
);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    assign at_last = (value == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (step) begin
            if (at_last) value <= '0;
            else         value <= value + 1'b1;
        end
    end
endmodule

// File: rtl/ofdm_symbol_timer.sv
module ofdm_symbol_timer
    import ofdm_seq_pkg::*;
#(
    parameter int USEFUL   = 512,
    parameter int CP_LONG  = 40,
    parameter int CP_SHORT = 36,
    parameter int SAMPLE_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                long_cp,
    output phase_t              phase,
    output logic [SAMPLE_W-1:0] sample,
    output logic                sym_last
);
    localparam logic [SAMPLE_W-1:0] LONG_GUARD_END  = SAMPLE_W'(CP_LONG - 1);
    localparam logic [SAMPLE_W-1:0] SHORT_GUARD_END = SAMPLE_W'(CP_SHORT - 1);
    localparam logic [SAMPLE_W-1:0] LONG_SYM_END    = SAMPLE_W'(CP_LONG + USEFUL - 1);
    localparam logic [SAMPLE_W-1:0] SHORT_SYM_END   = SAMPLE_W'(CP_SHORT + USEFUL - 1);

    phase_t phase_nxt;
    logic   guard_last;

    assign guard_last = (sample == (long_cp ? LONG_GUARD_END : SHORT_GUARD_END));
    assign sym_last   = (sample == (long_cp ? LONG_SYM_END : SHORT_SYM_END));

    // state register
    always_ff @(posedge clk) begin
        if (rst)     phase <= PH_GUARD;
        else if (en) phase <= phase_nxt;
    end

    // next-state logic
    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_GUARD: if (guard_last) phase_nxt = PH_BODY;
            PH_BODY:  if (sym_last)   phase_nxt = PH_GUARD;
        endcase
    end

    // sample counter
    always_ff @(posedge clk) begin
        if (rst) begin
            sample <= '0;
        end else if (en) begin
            if (sym_last) sample <= '0;
            else          sample <= sample + 1'b1;
        end
    end
endmodule

// File: rtl/ofdm_strobe_decode.sv
module ofdm_strobe_decode
    import ofdm_seq_pkg::*;
#(
    parameter int CP_LONG    = 40,
    parameter int CP_SHORT   = 36,
    parameter int LEAD       = 3,
    parameter int PSYNC_SYM  = 6,
    parameter int SSYNC_SYM  = 5,
    parameter int SYNC_SLOTA = 0,
    parameter int SYNC_SLOTB = 10,
    parameter int SAMPLE_W   = 10,
    parameter int SYM_W      = 3,
    parameter int SLOT_W     = 5
) (
    input  logic                en,
    input  phase_t              phase,
    input  logic                long_cp,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [SYM_W-1:0]    sym,
    input  logic [SLOT_W-1:0]   slot,
    output strobe_t             strobes
);
    localparam logic [SAMPLE_W-1:0] LONG_GO  = SAMPLE_W'(CP_LONG - LEAD);
    localparam logic [SAMPLE_W-1:0] SHORT_GO = SAMPLE_W'(CP_SHORT - LEAD);
    localparam logic [SYM_W-1:0]    PS_SYM   = SYM_W'(PSYNC_SYM);
    localparam logic [SYM_W-1:0]    SS_SYM   = SYM_W'(SSYNC_SYM);
    localparam logic [SLOT_W-1:0]   SLOT_A   = SLOT_W'(SYNC_SLOTA);
    localparam logic [SLOT_W-1:0]   SLOT_B   = SLOT_W'(SYNC_SLOTB);

    logic sync_slot;
    logic go_hit;

    assign sync_slot = (slot == SLOT_A) || (slot == SLOT_B);

    generate
        if (LEAD <= CP_SHORT) begin : g_lead_in_guard
            assign go_hit = (phase == PH_GUARD) &&
                            (sample == (long_cp ? LONG_GO : SHORT_GO));
        end else begin : g_lead_too_long
            assign go_hit = 1'b0;
        end
    endgenerate

    // output decode
    always_comb begin
        strobes = '0;
        if (en) begin
            unique case (phase)
                PH_GUARD: strobes.guard = 1'b1;
                PH_BODY:  strobes.body  = 1'b1;
            endcase
            strobes.psync    = sync_slot && (sym == PS_SYM);
            strobes.ssync    = sync_slot && (sym == SS_SYM);
            strobes.ifft_go  = go_hit;
            strobes.frame_go = (slot == '0) && (sym == '0) && (sample == '0);
        end
    end
endmodule

// File: rtl/ofdm_frame_sequencer.sv
module ofdm_frame_sequencer
    import ofdm_seq_pkg::*;
#(
    parameter int USEFUL     = 512,
    parameter int CP_LONG    = 40,
    parameter int CP_SHORT   = 36,
    parameter int SYMS       = 7,
    parameter int SLOTS      = 20,
    parameter int LEAD       = 3,
    parameter int PSYNC_SYM  = 6,
    parameter int SSYNC_SYM  = 5,
    parameter int SYNC_SLOTA = 0,
    parameter int SYNC_SLOTB = 10,
    parameter int SAMPLE_W   = $clog2(CP_LONG + USEFUL),
    parameter int SYM_W      = $clog2(SYMS),
    parameter int SLOT_W     = $clog2(SLOTS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    output logic                guard_flag,
    output logic                body_flag,
    output logic                psync_flag,
    output logic                ssync_flag,
    output logic                ifft_start,
    output logic                frame_start,
    output logic [SLOT_W-1:0]   slot_idx,
    output logic [SYM_W-1:0]    sym_idx,
    output logic [SAMPLE_W-1:0] sample_idx
);
    phase_t  phase;
    strobe_t strobes;
    logic    sym_last;
    logic    slot_last;
    logic    frame_last;
    logic    long_cp;

    assign long_cp = (sym_idx == '0);

    ofdm_symbol_timer #(
        .USEFUL  (USEFUL),
        .CP_LONG (CP_LONG),
        .CP_SHORT(CP_SHORT),
        .SAMPLE_W(SAMPLE_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .long_cp (long_cp),
        .phase   (phase),
        .sample  (sample_idx),
        .sym_last(sym_last)
    );

    ofdm_wrap_counter #(.LIMIT(SYMS), .W(SYM_W)) u_sym_cnt (
        .clk    (clk),
        .rst    (rst),
        .step   (en && sym_last),
        .value  (sym_idx),
        .at_last(slot_last)
    );

    ofdm_wrap_counter #(.LIMIT(SLOTS), .W(SLOT_W)) u_slot_cnt (
        .clk    (clk),
        .rst    (rst),
        .step   (en && sym_last && slot_last),
        .value  (slot_idx),
        .at_last(frame_last)
    );

    ofdm_strobe_decode #(
        .CP_LONG   (CP_LONG),
        .CP_SHORT  (CP_SHORT),
        .LEAD      (LEAD),
        .PSYNC_SYM (PSYNC_SYM),
        .SSYNC_SYM (SSYNC_SYM),
        .SYNC_SLOTA(SYNC_SLOTA),
        .SYNC_SLOTB(SYNC_SLOTB),
        .SAMPLE_W  (SAMPLE_W),
        .SYM_W     (SYM_W),
        .SLOT_W    (SLOT_W)
    ) u_decode (
        .en     (en),
        .phase  (phase),
        .long_cp(long_cp),
        .sample (sample_idx),
        .sym    (sym_idx),
        .slot   (slot_idx),
        .strobes(strobes)
    );

    assign guard_flag  = strobes.guard;
    assign body_flag   = strobes.body;
    assign psync_flag  = strobes.psync;
    assign ssync_flag  = strobes.ssync;
    assign ifft_start  = strobes.ifft_go;
    assign frame_start = strobes.frame_go;

    logic unused_last;
    assign unused_last = frame_last;
endmodule

// File: rtl/ofdm_frame_sequencer_chk.sv
module ofdm_frame_sequencer_chk #(
    parameter int SAMPLE_W = 10,
    parameter int SYM_W    = 3,
    parameter int SLOT_W   = 5
) (
    input logic                clk,
    input logic                rst,
    input logic                en,
    input logic                guard_flag,
    input logic                body_flag,
    input logic                psync_flag,
    input logic                ssync_flag,
    input logic                ifft_start,
    input logic                frame_start,
    input logic [SLOT_W-1:0]   slot_idx,
    input logic [SYM_W-1:0]    sym_idx,
    input logic [SAMPLE_W-1:0] sample_idx
);
    logic [2:0] age;

    always_ff @(posedge clk) begin
        if (rst)            age <= '0;
        else if (age != 7)  age <= age + 1'b1;
    end

    // R3
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(guard_flag && body_flag));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 2 && !en) |=> ($stable(sample_idx) && $stable(sym_idx) && $stable(slot_idx)));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> !(guard_flag || body_flag || psync_flag || ssync_flag || ifft_start || frame_start));

    // R2
    sample_step_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 2 && $past(en) && sample_idx != '0) |-> (sample_idx == $past(sample_idx) + 1'b1));

    // R4
    sym_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 2 && sym_idx != $past(sym_idx)) |-> ($past(body_flag) && sample_idx == '0));

    // R7
    ifft_lead_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 4 && $rose(body_flag) && $past(en, 1) && $past(en, 2) && $past(en, 3))
        |-> $past(ifft_start, 3));

    // R8
    frame_once_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    // R5
    psync_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 2 && $rose(psync_flag) && $past(en)) |-> (sample_idx == '0 && guard_flag));
endmodule

bind ofdm_frame_sequencer ofdm_frame_sequencer_chk #(
    .SAMPLE_W(SAMPLE_W),
    .SYM_W   (SYM_W),
    .SLOT_W  (SLOT_W)
) u_chk (.*);

// File: tb/ofdm_frame_sequencer_test.sv
module ofdm_frame_sequencer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b1;
    logic       guard_flag, body_flag, psync_flag, ssync_flag, ifft_start, frame_start;
    logic [4:0] slot_idx;
    logic [2:0] sym_idx;
    logic [9:0] sample_idx;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ofdm_frame_sequencer uut (
        .clk(clk), .rst(rst), .en(en),
        .guard_flag(guard_flag), .body_flag(body_flag),
        .psync_flag(psync_flag), .ssync_flag(ssync_flag),
        .ifft_start(ifft_start), .frame_start(frame_start),
        .slot_idx(slot_idx), .sym_idx(sym_idx), .sample_idx(sample_idx)
    );

    // cycle, slot, sym, sample, guard, body, psync, ssync, ifft, frame
    localparam int NV = 17;
    localparam int VEC [0:NV-1][0:9] = '{
        '{0,     0,  0, 0,   1, 0, 0, 0, 0, 1},
        '{37,    0,  0, 37,  1, 0, 0, 0, 1, 0},
        '{39,    0,  0, 39,  1, 0, 0, 0, 0, 0},
        '{40,    0,  0, 40,  0, 1, 0, 0, 0, 0},
        '{551,   0,  0, 551, 0, 1, 0, 0, 0, 0},
        '{552,   0,  1, 0,   1, 0, 0, 0, 0, 0},
        '{585,   0,  1, 33,  1, 0, 0, 0, 1, 0},
        '{588,   0,  1, 36,  0, 1, 0, 0, 0, 0},
        '{2744,  0,  5, 0,   1, 0, 0, 1, 0, 0},
        '{3292,  0,  6, 0,   1, 0, 1, 0, 0, 0},
        '{3839,  0,  6, 547, 0, 1, 1, 0, 0, 0},
        '{3840,  1,  0, 0,   1, 0, 0, 0, 0, 0},
        '{21944, 5,  5, 0,   1, 0, 0, 0, 0, 0},
        '{41144, 10, 5, 0,   1, 0, 0, 1, 0, 0},
        '{41692, 10, 6, 0,   1, 0, 1, 0, 0, 0},
        '{76799, 19, 6, 547, 0, 1, 0, 0, 0, 0},
        '{76800, 0,  0, 0,   1, 0, 0, 0, 0, 1}
    };

    // independent reference position
    int m_slot, m_sym, m_samp;

    task automatic model_step();
        int cpl = (m_sym == 0) ? 40 : 36;
        if (m_samp == cpl + 511) begin
            m_samp = 0;
            if (m_sym == 6) begin
                m_sym  = 0;
                m_slot = (m_slot == 19) ? 0 : m_slot + 1;
            end else begin
                m_sym = m_sym + 1;
            end
        end else begin
            m_samp = m_samp + 1;
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_model();
        int  cpl   = (m_sym == 0) ? 40 : 36;
        bit  syncs = (m_slot == 0) || (m_slot == 10);
        bit  e_g   = m_samp < cpl;
        chk("R2 sample_idx", sample_idx, m_samp);
        chk("R4 sym_idx", sym_idx, m_sym);
        chk("R4 slot_idx", slot_idx, m_slot);
        chk("R3 guard_flag", guard_flag, e_g);
        chk("R3 body_flag", body_flag, !e_g);
        chk("R5 psync_flag", psync_flag, syncs && m_sym == 6);
        chk("R6 ssync_flag", ssync_flag, syncs && m_sym == 5);
        chk("R7 ifft_start", ifft_start, m_samp == cpl - 3);
        chk("R8 frame_start", frame_start, m_slot == 0 && m_sym == 0 && m_samp == 0);
    endtask

    task automatic check_vec(input int k);
        chk("R4 vec slot", slot_idx, VEC[k][1]);
        chk("R4 vec sym", sym_idx, VEC[k][2]);
        chk("R2 vec sample", sample_idx, VEC[k][3]);
        chk("R3 vec guard", guard_flag, VEC[k][4]);
        chk("R3 vec body", body_flag, VEC[k][5]);
        chk("R5 vec psync", psync_flag, VEC[k][6]);
        chk("R6 vec ssync", ssync_flag, VEC[k][7]);
        chk("R7 vec ifft", ifft_start, VEC[k][8]);
        chk("R8 vec frame", frame_start, VEC[k][9]);
    endtask

    task automatic check_quiet(input string tag);
        chk({tag, " guard"}, guard_flag, 0);
        chk({tag, " body"}, body_flag, 0);
        chk({tag, " psync"}, psync_flag, 0);
        chk({tag, " ssync"}, ssync_flag, 0);
        chk({tag, " ifft"}, ifft_start, 0);
        chk({tag, " frame"}, frame_start, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int vi = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        #1;
        chk("R1 slot", slot_idx, 0);
        chk("R1 sym", sym_idx, 0);
        chk("R1 sample", sample_idx, 0);
        chk("R1 guard", guard_flag, 1);
        m_slot = 0; m_sym = 0; m_samp = 0;
        rst = 1'b0;

        // one full frame plus one sample, compared every cycle
        for (int cyc = 0; cyc <= 76800; cyc++) begin
            #1;
            check_model();
            if (vi < NV && VEC[vi][0] == cyc) begin
                check_vec(vi);
                vi++;
            end
            @(posedge clk);
            model_step();
            @(negedge clk);
        end

        // R9: freeze at sample 37, where the IFFT pulse would fire
        while (sample_idx != 10'd37) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
        end
        en = 1'b0;
        #1;
        check_quiet("R9 idle");
        for (int i = 0; i < 5; i++) begin
            @(posedge clk);
            @(negedge clk);
            #1;
            chk("R9 hold sample", sample_idx, 37);
            chk("R9 hold sym", sym_idx, m_sym);
            chk("R9 hold slot", slot_idx, m_slot);
            check_quiet("R9 idle");
        end
        @(negedge clk);
        en = 1'b1;
        #1;
        chk("R7 pulse after resume", ifft_start, 1);
        check_model();
        // R7: body rises exactly 3 clocks later
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            #1;
            chk("R7 body after lead", body_flag, (i == 2) ? 1 : 0);
        end

        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1 mid slot", slot_idx, 0);
        chk("R1 mid sym", sym_idx, 0);
        chk("R1 mid sample", sample_idx, 0);
        chk("R1 mid guard", guard_flag, 1);
        chk("R1 mid body", body_flag, 0);
        rst = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule